// File: doc/BRIEF.md
# Bus Access Wait-State Calculator

This block tells the processor how many clock cycles a single bus access takes. It uses the access address, the transfer size and whether the access continues a sequential burst. The memory map is split into sixteen regions, chosen by a 4-bit field of the address. Fast internal memories cost one cycle. Video memories pay an extra cycle for a full word. The external work RAM costs an amount set by a software wait field. The cartridge regions use programmable nonsequential (N) and sequential (S) wait counts, with one pair for each wait bank.

The block also holds a one-bit "force nonsequential" flag for the processor side. An idle cycle sets the flag, and so does a completed store. The next access is then costed as nonsequential, and the flag is cleared by it. Cartridge accesses that land on a 128 KB page boundary are always costed as nonsequential, because the external bus must restart its address there.

The cost output is purely combinational from the current inputs and the registered flag. The surrounding sequencer can therefore use it in the same cycle that it presents an access.

Top module: `bus_wait_calc`

## Requirements
- R1: The region is the address field [27:24]. Address bits [31:28] never change the cost.
- R2: Regions 0, 1, 3, 4 and 7 cost exactly 1 cycle for any size and mode.
- R3: Regions 5 and 6 cost 1 cycle for byte and half accesses and 2 cycles for word accesses. Size encoding: 2'b00 byte, 2'b01 half, 2'b10 word, and 2'b11 is costed like a half.
- R4: Region 2 costs (16 minus `ewram_wait_i`) for byte and half accesses and twice that for word accesses.
- R5: Regions 8-9 use wait bank 0, regions 10-11 use bank 1 and regions 12-13 use bank 2. Bank k takes N from `rom_n_wait_i[4k+3:4k]` and S from `rom_s_wait_i[4k+3:4k]`. Regions 14-15 use `save_wait_i` for both N and S.
- R6: A cartridge access costs S when resolved sequential and N otherwise. A word access adds one further S.
- R7: A cartridge access whose address bits [16:1] are all zero is resolved nonsequential even when `seq_i` is 1.
- R8: A cycle with `idle_i` high sets the flag at the next edge, even if an access happens in that same cycle. While the flag is set, the next access is resolved nonsequential (`seq_i` ignored).
- R9: An access with `store_i` high and `idle_i` low leaves the flag set after it.
- R10: An access with `store_i` low and `idle_i` low clears the flag. Without `acc_i` or `idle_i` the flag holds.
- R11: After reset the flag is clear, so a sequential cartridge request away from a page boundary costs S (plus S for a word).
- R12: The requested mode and the flag affect only cartridge regions 8-15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Access address |
| size_i | input | 2 | Transfer size (00 byte, 01 half, 10 word) |
| seq_i | input | 1 | Requested mode, 1 = sequential |
| acc_i | input | 1 | An access (read, load or write) completes this cycle |
| store_i | input | 1 | The access this cycle is a store |
| idle_i | input | 1 | Processor idle cycle |
| ewram_wait_i | input | 4 | External work RAM wait control field |
| rom_n_wait_i | input | 12 | N wait counts, 4 bits per cartridge bank |
| rom_s_wait_i | input | 12 | S wait counts, 4 bits per cartridge bank |
| save_wait_i | input | 4 | Wait count for the save-memory regions |
| cycles_o | output | 6 | Cycle count of the current access |

## Verification
The bench runs a behavioural model beside the block and compares the cost on every cycle. Directed patterns come first. They sweep every region with every size, which separates the fixed-cost, video, work-RAM and cartridge rules. They hit the work-RAM field at both ends, so a subtraction error shows against a doubling error. They also place cartridge addresses exactly on and next to a 128 KB boundary. Sequences of idle, store and plain accesses followed by a sequential cartridge read show which event last touched the flag. A long random phase then mixes regions, sizes, strobes and wait settings, including idle and access in the same cycle.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        RC_FAST  = 2'd0,
        RC_VIDEO = 2'd1,
        RC_EWRAM = 2'd2,
        RC_CART  = 2'd3
    } region_class_e;

    typedef struct packed {
        logic force_ns;
    } track_s;

endpackage

// File: rtl/bwc_region_decode.sv
module bwc_region_decode
    import bwc_pkg::*;
(
    input  logic [3:0]    region_i,
    output region_class_e class_o,
    output logic [1:0]    bank_o
);

    always_comb begin
        unique case (region_i)
            4'h0, 4'h1, 4'h3, 4'h4, 4'h7: class_o = RC_FAST;
            4'h5, 4'h6:                   class_o = RC_VIDEO;
            4'h2:                         class_o = RC_EWRAM;
            default:                      class_o = RC_CART;
        endcase
        // pairs of regions share a bank: 8/9, A/B, C/D, E/F
        bank_o = region_i[2:1];
    end

endmodule

// File: rtl/bwc_cart_cost.sv
module bwc_cart_cost #(
    parameter int NUM_WS = 3,
    parameter int WAIT_W = 4,
    parameter int CYC_W  = 6
) (
    input  logic [1:0]             bank_i,
    input  logic                   seq_i,
    input  logic                   page_zero_i,
    input  logic                   is_word_i,
    input  logic [NUM_WS*WAIT_W-1:0] n_waits_i,
    input  logic [NUM_WS*WAIT_W-1:0] s_waits_i,
    input  logic [WAIT_W-1:0]      save_wait_i,
    output logic [CYC_W-1:0]       cost_o
);

    localparam int NB = 4;

    logic [WAIT_W-1:0] n_tab [NB];
    logic [WAIT_W-1:0] s_tab [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        if (g < NUM_WS) begin : g_rom
            assign n_tab[g] = n_waits_i[g*WAIT_W +: WAIT_W];
            assign s_tab[g] = s_waits_i[g*WAIT_W +: WAIT_W];
        end else begin : g_save
            assign n_tab[g] = save_wait_i;
            assign s_tab[g] = save_wait_i;
        end
    end

    logic              res_seq;
    logic [WAIT_W-1:0] sel_n, sel_s, base;

    always_comb begin
        sel_n   = n_tab[bank_i];
        sel_s   = s_tab[bank_i];
        res_seq = seq_i && !page_zero_i;
        base    = res_seq ? sel_s : sel_n;
        cost_o  = CYC_W'(base) + (is_word_i ? CYC_W'(sel_s) : CYC_W'(0));
    end

endmodule

// File: rtl/bwc_ns_tracker.sv
module bwc_ns_tracker
    import bwc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic acc_i,
    input  logic store_i,
    input  logic idle_i,
    output logic force_ns_o
);

    track_s trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (idle_i)     trk_d.force_ns = 1'b1;
        else if (acc_i) trk_d.force_ns = store_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trk_q <= '0;
        else         trk_q <= trk_d;
    end

    assign force_ns_o = trk_q.force_ns;

    // R8
    a_r8_idle_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_i |=> force_ns_o);
    // R9
    a_r9_store_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i && store_i && !idle_i) |=> force_ns_o);
    // R10
    a_r10_access_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i && !store_i && !idle_i) |=> !force_ns_o);
    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!acc_i && !idle_i) |=> $stable(force_ns_o));

endmodule

// File: rtl/bus_wait_calc.sv
module bus_wait_calc
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_WS = 3,
    parameter int WAIT_W = 4,
    parameter int EW_W   = 4,
    parameter int CYC_W  = 6
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [1:0]               size_i,
    input  logic                     seq_i,
    input  logic                     acc_i,
    input  logic                     store_i,
    input  logic                     idle_i,
    input  logic [EW_W-1:0]          ewram_wait_i,
    input  logic [NUM_WS*WAIT_W-1:0] rom_n_wait_i,
    input  logic [NUM_WS*WAIT_W-1:0] rom_s_wait_i,
    input  logic [WAIT_W-1:0]        save_wait_i,
    output logic [CYC_W-1:0]         cycles_o
);

    localparam int EW_SPAN = 1 << EW_W;

    logic [3:0]      region;
    region_class_e   rclass;
    logic [1:0]      bank;
    logic            is_word, page_zero, force_ns, eff_seq;
    logic [CYC_W-1:0] cart_cost, ew_cost;
    logic            unused_addr;

    assign region      = addr_i[27:24];
    assign page_zero   = (addr_i[16:1] == '0);
    assign unused_addr = ^{addr_i[ADDR_W-1:28], addr_i[23:17], addr_i[0]};
    assign is_word     = (size_i == SZ_WORD);

    bwc_region_decode u_dec (
        .region_i (region),
        .class_o  (rclass),
        .bank_o   (bank)
    );

    bwc_ns_tracker u_trk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .acc_i      (acc_i),
        .store_i    (store_i),
        .idle_i     (idle_i),
        .force_ns_o (force_ns)
    );

    assign eff_seq = seq_i && !force_ns;

    bwc_cart_cost #(
        .NUM_WS (NUM_WS),
        .WAIT_W (WAIT_W),
        .CYC_W  (CYC_W)
    ) u_cart (
        .bank_i      (bank),
        .seq_i       (eff_seq),
        .page_zero_i (page_zero),
        .is_word_i   (is_word),
        .n_waits_i   (rom_n_wait_i),
        .s_waits_i   (rom_s_wait_i),
        .save_wait_i (save_wait_i),
        .cost_o      (cart_cost)
    );

    always_comb begin
        ew_cost = CYC_W'(EW_SPAN) - CYC_W'(ewram_wait_i);
        if (is_word) ew_cost = ew_cost << 1;
        unique case (rclass)
            RC_FAST:  cycles_o = CYC_W'(1);
            RC_VIDEO: cycles_o = is_word ? CYC_W'(2) : CYC_W'(1);
            RC_EWRAM: cycles_o = ew_cost;
            default:  cycles_o = cart_cost;
        endcase
    end

    // R2
    a_r2_fast_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i && (addr_i[27:24] inside {4'h0, 4'h1, 4'h3, 4'h4, 4'h7}))
        |-> cycles_o == CYC_W'(1));
    // R3
    a_r3_video: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i && (addr_i[27:24] inside {4'h5, 4'h6}))
        |-> cycles_o == ((size_i == 2'b10) ? CYC_W'(2) : CYC_W'(1)));
    // R4
    a_r4_ewram_word_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i && addr_i[27:24] == 4'h2 && size_i == 2'b10) |-> !cycles_o[0]);
    // R4
    a_r4_ewram_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_i && addr_i[27:24] == 4'h2) |-> cycles_o != '0);

endmodule

// File: tb/sim_bus_wait_calc.sv
module sim_bus_wait_calc;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic        seq = 1'b0, acc = 1'b0, store = 1'b0, idle = 1'b0;
    logic [3:0]  ewram = '0;
    logic [11:0] rom_n = '0, rom_s = '0;
    logic [3:0]  save_w = '0;
    logic [5:0]  cycles;

    int n_chk = 0, n_fail = 0;
    bit    m_flag = 1'b0;
    string m_src = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_wait_calc u0 (
        .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .size_i (size),
        .seq_i (seq), .acc_i (acc), .store_i (store), .idle_i (idle),
        .ewram_wait_i (ewram), .rom_n_wait_i (rom_n), .rom_s_wait_i (rom_s),
        .save_wait_i (save_w), .cycles_o (cycles)
    );

    function automatic int ref_cost(logic [31:0] a, logic [1:0] sz, bit sq, bit flag);
        int  r = int'(a[27:24]);
        bit  w = (sz == 2'b10);
        int  n, s, b;
        bit  rs;
        if (r == 0 || r == 1 || r == 3 || r == 4 || r == 7) return 1;
        if (r == 5 || r == 6) return w ? 2 : 1;
        if (r == 2) return (16 - int'(ewram)) * (w ? 2 : 1);
        b = (r - 8) / 2;
        if (b < 3) begin
            n = int'(rom_n[b*4 +: 4]);
            s = int'(rom_s[b*4 +: 4]);
        end else begin
            n = int'(save_w);
            s = int'(save_w);
        end
        rs = sq && !flag && (a[16:1] != 16'd0);
        return (rs ? s : n) + (w ? s : 0);
    endfunction

    task automatic step(input logic [31:0] a, input logic [1:0] sz, input bit sq,
                        input bit ac, input bit st, input bit id, input string extra);
        int    exp;
        string tag;
        int    r;
        addr = a; size = sz; seq = sq; acc = ac; store = st; idle = id;
        #1;
        exp = ref_cost(a, sz, sq, m_flag);
        r = int'(a[27:24]);
        if (r >= 8) tag = {"R5 R6 R12 ", m_src, (a[16:1] == 16'd0) ? " R7" : ""};
        else if (r == 2) tag = "R4";
        else if (r == 5 || r == 6) tag = "R3";
        else tag = "R2";
        tag = {tag, " ", extra};
        n_chk++;
        if (int'(cycles) != exp) begin
            n_fail++;
            $display("FAIL %s addr=%h size=%0d seq=%0d: actual %0d expected %0d",
                     tag, a, sz, sq, cycles, exp);
        end
        @(posedge clk);
        if (id) begin
            m_flag = 1'b1; m_src = "R8";
        end else if (ac) begin
            m_flag = st; m_src = st ? "R9" : "R10";
        end
        @(negedge clk);
        acc = 1'b0; store = 1'b0; idle = 1'b0;
    endtask

    function automatic logic [31:0] cart_addr(int region, bit boundary);
        logic [31:0] a;
        a = {4'h0, region[3:0], 8'h00, 16'h0000};
        if (!boundary) a[16:1] = 16'h0123;
        return a;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        ewram = 4'd13; save_w = 4'd8;
        rom_n = {4'd9, 4'd5, 4'd4}; rom_s = {4'd7, 4'd3, 4'd2};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: flag clear after reset, sequential cartridge read costs S
        step(cart_addr(8, 0), 2'b01, 1, 1, 0, 0, "R11");
        // R1: upper bits do not matter
        step(32'hF300_0010, 2'b10, 0, 1, 0, 0, "R1");
        step(32'hA500_0000, 2'b10, 1, 1, 0, 0, "R1");
        step(32'h7000_0000 | cart_addr(9, 0), 2'b10, 1, 1, 0, 0, "R1");
        // all regions, all sizes
        for (int r = 0; r < 16; r++)
            for (int z = 0; z < 4; z++)
                step(r < 8 ? {4'h0, r[3:0], 24'h000040} : cart_addr(r, 0),
                     z[1:0], 1, 1, 0, 0, "sweep");
        // R4: field ends
        ewram = 4'd0;  step(32'h0200_0000, 2'b10, 0, 1, 0, 0, "R4");
        ewram = 4'd15; step(32'h0200_0000, 2'b00, 0, 1, 0, 0, "R4");
        step(32'h0200_0000, 2'b10, 0, 1, 0, 0, "R4");
        // R7: boundary vs neighbour
        step(cart_addr(10, 1), 2'b01, 1, 1, 0, 0, "R7");
        step(cart_addr(10, 1) | 32'h2, 2'b01, 1, 1, 0, 0, "R7");
        step(cart_addr(12, 1) | 32'h1, 2'b00, 1, 1, 0, 0, "R7");
        // R8: idle then sequential read
        step(32'h0300_0000, 2'b00, 0, 0, 0, 1, "R8");
        step(cart_addr(8, 0), 2'b10, 1, 1, 0, 0, "R8");
        step(cart_addr(8, 0), 2'b10, 1, 1, 0, 0, "R10");
        // R8: idle together with access
        step(cart_addr(14, 0), 2'b01, 1, 1, 0, 1, "R8");
        step(cart_addr(14, 0), 2'b01, 1, 1, 0, 0, "R8");
        // R9: store then read
        step(cart_addr(12, 0), 2'b10, 1, 1, 1, 0, "R9");
        step(32'h0600_0000, 2'b10, 1, 0, 0, 0, "R12");
        step(cart_addr(12, 0), 2'b10, 1, 1, 0, 0, "R9");
        // R10: plain access cleared it
        step(cart_addr(12, 0), 2'b10, 1, 1, 0, 0, "R10");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            if (i % 500 == 0) begin
                ewram = 4'($urandom); save_w = 4'($urandom);
                rom_n = 12'($urandom); rom_s = 12'($urandom);
            end
            a = $urandom;
            if ($urandom_range(0, 7) == 0) a[16:1] = 16'd0;
            step(a, 2'($urandom_range(0, 3)), 1'($urandom),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 5) == 0, "rnd");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule